// File: doc/BRIEF.md
# TDM Slot Receive Deserializer

This block turns the serial data line of a time-division-multiplexed codec link into parallel 16-bit words. The serial clock, frame sync and data arrive as plain inputs that are synchronous to the system clock. The block detects the chosen serial-clock edge and samples there. A frame sync seen on a sampling edge starts a frame. The frame is then cut into up to sixteen back-to-back slots, and every slot has the same programmable length.

A 16-bit slot mask decides which slots are kept. For each kept slot the block issues one buffer write of a single left-justified word, which carries the slot index and the current buffer pointer, and then the pointer moves on. Slots that are not kept are still clocked through, but they produce no write. After the highest kept slot has ended, the block ignores the line until the next frame sync. The buffer memory and the frame-sync source are outside this block.

Top module: `tdm_rx_deser`

## Requirements
- R1: While reset is held and right after it, `wr_en` is 0 and `wr_ptr` is 0. Serial activity without a frame sync causes no write.
- R2: With `cfg_sample_rise` = 0, `sdin` and `fsync` are sampled on the falling edge of `sclk`. With `cfg_sample_rise` = 1, they are sampled on the rising edge.
- R3: With `cfg_same_edge` = 0, bit 0 of slot 0 is taken on the sampling edge that follows the edge on which `fsync` is seen high, and the bit present with the sync is ignored. With `cfg_same_edge` = 1, the sync edge itself carries bit 0 of slot 0.
- R4: Every slot is `cfg_word_len` + 1 bits long, from 1 bit (value 0) to 16 bits (value 15), and slot n+1 starts on the sampling edge right after the last bit of slot n.
- R5: A stored word is left justified. The first bit received in the slot lands in `wr_data[15]`, and the bits below the slot length are 0.
- R6: A slot whose bit in `cfg_slot_mask` (bit n for slot n) is 0 is shifted past without a write. Each slot whose bit is 1 yields exactly one write.
- R7: Each write is a single-cycle `wr_en` pulse that comes one system-clock cycle after the sampling edge of the slot's last bit. It carries the slot index on `wr_slot`.
- R8: `wr_ptr` is 0 for the first write after reset and goes up by one with each write. It wraps from BUF_DEPTH-1 (default 8 entries) to 0, and it is not cleared by a frame sync.
- R9: After the last bit of the highest-numbered enabled slot, no write occurs until the next frame sync. With a mask of all zeros, a frame produces no write.
- R10: A frame sync seen in the middle of a frame abandons that frame. Counting restarts at slot 0, and the partial slot is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sample_rise | input | 1 | 1: sample on rising `sclk` edge, 0: falling |
| cfg_same_edge | input | 1 | 1: first data bit shares the sync edge, 0: one edge later |
| cfg_word_len | input | 4 | Slot length minus one |
| cfg_slot_mask | input | 16 | Per-slot capture enable, bit n for slot n |
| sclk | input | 1 | Serial bit clock, synchronous to `clk` |
| fsync | input | 1 | Frame sync, sampled on the sampling edge |
| sdin | input | 1 | Serial data |
| wr_en | output | 1 | Buffer write strobe, one cycle per word |
| wr_data | output | 16 | Left-justified received word |
| wr_slot | output | 4 | Slot index of the word |
| wr_ptr | output | PTR_W (3) | Buffer location for the word |

## Verification
A bit counter that is off by one shifts every later word by one bit position. The first word's data shows it, no more than one slot after the sync. A slot counter or mask error shows up as a wrong `wr_slot`, an extra write or a missing write, all within the same frame. A stale active flag after the last enabled slot appears as a write in the trailing idle bits that the bench sends after every frame. A pointer fault shows on the very next write address.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int WORD_W    = 16;
  localparam int NUM_SLOTS = 16;
  localparam int LEN_W     = $clog2(WORD_W);
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  typedef logic [WORD_W-1:0]    word_t;
  typedef logic [LEN_W-1:0]     len_t;
  typedef logic [SLOT_W-1:0]    slot_t;
  typedef logic [NUM_SLOTS-1:0] mask_t;

  // Move the low (wlen+1) bits of raw to the top of the word; older bits fall off.
  function automatic word_t left_justify(word_t raw, len_t wlen);
    return raw << (WORD_W - 1 - int'(wlen));
  endfunction

  // Bits of a word that lie below a slot of length wlen+1.
  function automatic word_t unused_bits(len_t wlen);
    return ~left_justify('1, wlen);
  endfunction

  // Index of the highest enabled slot (0 when none is enabled).
  function automatic slot_t last_enabled(mask_t m);
    slot_t r;
    r = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (m[i]) r = slot_t'(i);
    return r;
  endfunction
endpackage

// File: rtl/tdm_rx_edge.sv
module tdm_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sample_rise,
  output logic samp_evt
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  logic rise_evt, fall_evt;
  assign rise_evt = sclk & ~sclk_q;
  assign fall_evt = ~sclk & sclk_q;
  assign samp_evt = sample_rise ? rise_evt : fall_evt;
endmodule

// File: rtl/tdm_rx_slot_seq.sv
module tdm_rx_slot_seq
  import tdm_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  samp_evt,
  input  logic  fsync,
  input  logic  same_edge,
  input  len_t  wlen,
  input  mask_t mask,
  output logic  frame_start,
  output logic  bit_take,
  output logic  slot_end,
  output logic  store_evt,
  output logic  frame_active,
  output slot_t cur_slot
);
  slot_t slot_q;
  len_t  bit_q;
  len_t  cur_bit;
  logic  any_en;
  logic  last_end;

  assign any_en      = |mask;
  assign frame_start = samp_evt & fsync;
  assign cur_slot    = frame_start ? '0 : slot_q;
  assign cur_bit     = frame_start ? '0 : bit_q;
  assign bit_take    = frame_start ? (same_edge & any_en) : (samp_evt & frame_active);
  assign slot_end    = bit_take && (cur_bit == wlen);
  assign store_evt   = slot_end && mask[cur_slot];
  assign last_end    = slot_end && (cur_slot == last_enabled(mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q       <= '0;
      bit_q        <= '0;
      frame_active <= 1'b0;
    end else begin
      if (frame_start || bit_take) begin
        if (slot_end) begin
          slot_q <= cur_slot + 1'b1;
          bit_q  <= '0;
        end else begin
          slot_q <= cur_slot;
          bit_q  <= bit_take ? cur_bit + 1'b1 : cur_bit;
        end
      end
      frame_active <= (frame_start ? any_en : frame_active) && !last_end;
    end
  end
endmodule

// File: rtl/tdm_rx_word_asm.sv
module tdm_rx_word_asm
  import tdm_rx_pkg::*;
#(
  parameter int BUF_DEPTH = 8,
  parameter int PTR_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_take,
  input  logic             store_evt,
  input  logic             sdin,
  input  len_t             wlen,
  input  slot_t            cur_slot,
  output logic             wr_en,
  output word_t            wr_data,
  output slot_t            wr_slot,
  output logic [PTR_W-1:0] wr_ptr
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(BUF_DEPTH - 1);

  word_t            shreg;
  word_t            shreg_next;
  logic [PTR_W-1:0] ptr_q;

  assign shreg_next = {shreg[WORD_W-2:0], sdin};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      ptr_q   <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      wr_slot <= '0;
      wr_ptr  <= '0;
    end else begin
      wr_en <= store_evt;
      if (bit_take) shreg <= shreg_next;
      if (store_evt) begin
        wr_data <= left_justify(shreg_next, wlen);
        wr_slot <= cur_slot;
        wr_ptr  <= ptr_q;
        ptr_q   <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdm_rx_pkg::*;
#(
  parameter int BUF_DEPTH = 8,
  parameter int PTR_W     = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sample_rise,
  input  logic             cfg_same_edge,
  input  logic [3:0]       cfg_word_len,
  input  logic [15:0]      cfg_slot_mask,
  input  logic             sclk,
  input  logic             fsync,
  input  logic             sdin,
  output logic             wr_en,
  output logic [15:0]      wr_data,
  output logic [3:0]       wr_slot,
  output logic [PTR_W-1:0] wr_ptr
);
  logic  samp_evt;
  logic  frame_start;
  logic  bit_take;
  logic  slot_end;
  logic  store_evt;
  logic  frame_active;
  slot_t cur_slot;

  tdm_rx_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .sample_rise (cfg_sample_rise),
    .samp_evt    (samp_evt)
  );

  tdm_rx_slot_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .samp_evt     (samp_evt),
    .fsync        (fsync),
    .same_edge    (cfg_same_edge),
    .wlen         (cfg_word_len),
    .mask         (cfg_slot_mask),
    .frame_start  (frame_start),
    .bit_take     (bit_take),
    .slot_end     (slot_end),
    .store_evt    (store_evt),
    .frame_active (frame_active),
    .cur_slot     (cur_slot)
  );

  tdm_rx_word_asm #(.BUF_DEPTH(BUF_DEPTH), .PTR_W(PTR_W)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_take  (bit_take),
    .store_evt (store_evt),
    .sdin      (sdin),
    .wlen      (cfg_word_len),
    .cur_slot  (cur_slot),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_slot   (wr_slot),
    .wr_ptr    (wr_ptr)
  );
endmodule

// File: rtl/tdm_rx_deser_chk.sv
module tdm_rx_deser_chk
  import tdm_rx_pkg::*;
#(
  parameter int BUF_DEPTH = 8,
  parameter int PTR_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       cfg_word_len,
  input logic [15:0]      cfg_slot_mask,
  input logic             frame_start,
  input logic             frame_active,
  input logic             slot_end,
  input logic             store_evt,
  input logic [3:0]       cur_slot,
  input logic             wr_en,
  input logic [15:0]      wr_data,
  input logic [3:0]       wr_slot,
  input logic [PTR_W-1:0] wr_ptr
);
  logic [PTR_W-1:0] prev_ptr;
  logic             have_prev;
  logic [PTR_W-1:0] want_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ptr  <= '0;
      have_prev <= 1'b0;
    end else if (wr_en) begin
      prev_ptr  <= wr_ptr;
      have_prev <= 1'b1;
    end
  end
  assign want_ptr = (prev_ptr == PTR_W'(BUF_DEPTH - 1)) ? '0 : prev_ptr + 1'b1;

  // R7: a write strobe lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R7: the end of a kept slot is written one cycle later with its index
  a_r7_store_to_write: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> (wr_en && wr_slot == $past(cur_slot)));
  // R6: only enabled slots are written
  a_r6_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cfg_slot_mask[wr_slot]);
  // R6: every finished enabled slot is stored
  a_r6_end_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && cfg_slot_mask[cur_slot]) |-> store_evt);
  // R5: bits below the slot length are zero
  a_r5_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data & unused_bits(cfg_word_len)) == '0));
  // R8: each write uses the location after the previous one
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && have_prev) |-> (wr_ptr == want_ptr));
  // R9: no slot completes outside a frame
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_active && !frame_start) |-> !slot_end);
  // R9: an all-zero mask never stores
  a_r9_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_slot_mask == '0) |-> !store_evt);
endmodule

bind tdm_rx_deser tdm_rx_deser_chk #(.BUF_DEPTH(BUF_DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_word_len  (cfg_word_len),
  .cfg_slot_mask (cfg_slot_mask),
  .frame_start   (frame_start),
  .frame_active  (frame_active),
  .slot_end      (slot_end),
  .store_evt     (store_evt),
  .cur_slot      (cur_slot),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .wr_slot       (wr_slot),
  .wr_ptr        (wr_ptr)
);

// File: tb/test_tdm_rx_deser.sv
module test_tdm_rx_deser;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int NV         = 6;
  // {rise, same_edge, word_len, mask, seed, expected write count}
  localparam logic [58:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd7,  16'h0005, 32'hA5C31F20, 5'd2},
    {1'b1, 1'b0, 4'd15, 16'h0003, 32'h1234ABCD, 5'd2},
    {1'b0, 1'b1, 4'd0,  16'hA001, 32'hDEADBEEF, 5'd3},
    {1'b1, 1'b1, 4'd3,  16'h0110, 32'h0F0F3C3C, 5'd2},
    {1'b0, 1'b0, 4'd11, 16'h0008, 32'h96E1705B, 5'd1},
    {1'b1, 1'b0, 4'd4,  16'h0000, 32'h55AA33CC, 5'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sample_rise = 1'b0, cfg_same_edge = 1'b0;
  logic [3:0] cfg_word_len = 4'd0;
  logic [15:0] cfg_slot_mask = 16'h0;
  logic sclk = 1'b0, fsync = 1'b0, sdin = 1'b0;
  logic wr_en;
  logic [15:0] wr_data;
  logic [3:0] wr_slot;
  logic [2:0] wr_ptr;

  int tests = 0, fails = 0;
  logic samp_lvl = 1'b0;
  logic [15:0] got_data [64];
  logic [3:0]  got_slot [64];
  logic [2:0]  got_ptr  [64];
  int got_n = 0;
  logic prev_en = 1'b0;
  int exp_ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_rx_deser #(.BUF_DEPTH(DEPTH)) i_tdm_rx_deser (
    .clk(clk), .rst_n(rst_n), .cfg_sample_rise(cfg_sample_rise),
    .cfg_same_edge(cfg_same_edge), .cfg_word_len(cfg_word_len),
    .cfg_slot_mask(cfg_slot_mask), .sclk(sclk), .fsync(fsync), .sdin(sdin),
    .wr_en(wr_en), .wr_data(wr_data), .wr_slot(wr_slot), .wr_ptr(wr_ptr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: collect writes; R7 single-cycle pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en && prev_en) chk(1'b0, "R7 pulse longer than one cycle", 32'd2, 32'd1);
      if (wr_en && got_n < 64) begin
        got_data[got_n] = wr_data;
        got_slot[got_n] = wr_slot;
        got_ptr[got_n]  = wr_ptr;
        got_n++;
      end
    end
    prev_en = wr_en;
  end

  function automatic logic bit_of(logic [31:0] s, int i);
    return s[(i * 7 + 1) % 32] ^ i[1];
  endfunction

  task automatic serial_bit(input logic fs, input logic d);
    sclk = ~samp_lvl; fsync = fs; sdin = d;
    repeat (2) @(negedge clk);
    sclk = samp_lvl;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cfg(input logic rise, input logic same, input logic [3:0] wl, input logic [15:0] mk);
    cfg_sample_rise = rise; cfg_same_edge = same; cfg_word_len = wl; cfg_slot_mask = mk;
    samp_lvl = rise; sclk = ~rise; fsync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // R2/R3/R4/R5/R6/R8/R9: one frame plus idle trailing bits, then compare
  task automatic run_frame(input logic rise, input logic same, input logic [3:0] wl,
                           input logic [15:0] mk, input logic [31:0] seed, input int extra, input int exp_cnt);
    logic [15:0] e_data [16];
    logic [3:0]  e_slot [16];
    int e_ptr [16];
    int n = 0;
    int last = -1;
    int len = int'(wl) + 1;
    set_cfg(rise, same, wl, mk);
    for (int s = 0; s < 16; s++) if (mk[s]) last = s;
    for (int s = 0; s <= last; s++) begin
      if (mk[s]) begin
        logic [15:0] w = '0;
        for (int b = 0; b < len; b++) w[15-b] = bit_of(seed, s * len + b);
        e_data[n] = w; e_slot[n] = 4'(s); e_ptr[n] = exp_ptr;
        exp_ptr = (exp_ptr + 1) % DEPTH;
        n++;
      end
    end
    if (exp_cnt >= 0) chk(n == exp_cnt, "R6 table count", 32'(n), 32'(exp_cnt));
    got_n = 0;
    if (!same) serial_bit(1'b1, 1'b1);  // R3: bit with the sync is ignored
    for (int i = 0; i < (last + 1 + extra) * len; i++)
      serial_bit(same && i == 0, bit_of(seed, i));
    repeat (3) @(negedge clk);
    chk(got_n == n, "R9 write count per frame", 32'(got_n), 32'(n));
    for (int k = 0; k < n && k < got_n; k++) begin
      chk(got_data[k] == e_data[k], "R5 word data (R2/R3/R4)", 32'(got_data[k]), 32'(e_data[k]));
      chk(got_slot[k] == e_slot[k], "R7 slot index", 32'(got_slot[k]), 32'(e_slot[k]));
      chk(int'(got_ptr[k]) == e_ptr[k], "R8 pointer", 32'(got_ptr[k]), 32'(e_ptr[k]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0, "R1 wr_en in reset", 32'(wr_en), 32'd0);
    chk(wr_ptr == 3'd0, "R1 wr_ptr in reset", 32'(wr_ptr), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: serial activity without sync writes nothing
    set_cfg(1'b0, 1'b0, 4'd3, 16'hFFFF);
    got_n = 0;
    for (int i = 0; i < 12; i++) serial_bit(1'b0, i[0]);
    repeat (2) @(negedge clk);
    chk(got_n == 0, "R1 no write without sync", 32'(got_n), 32'd0);
    chk(wr_ptr == 3'd0, "R1 pointer after idle", 32'(wr_ptr), 32'd0);

    // Table walk
    for (int v = 0; v < NV; v++)
      run_frame(VEC[v][58], VEC[v][57], VEC[v][56:53], VEC[v][52:37], VEC[v][36:5],
                (VEC[v][52:37] == 16'h0) ? 4 : 2, int'(VEC[v][4:0]));

    // R10: sync in the middle of a slot restarts the frame
    set_cfg(1'b0, 1'b0, 4'd7, 16'h0003);
    got_n = 0;
    serial_bit(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) serial_bit(1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk(got_n == 0, "R10 partial slot not written", 32'(got_n), 32'd0);
    run_frame(1'b0, 1'b0, 4'd7, 16'h0003, 32'h3C5A0FF1, 2, 2);

    // R4/R9: single-bit slots, last slot 15 only, same-edge start
    run_frame(1'b1, 1'b1, 4'd0, 16'h8000, 32'h7777ABCD, 3, 1);
    // R4: full 16-bit slots with rising edge, all of the first three slots
    run_frame(1'b1, 1'b0, 4'd15, 16'h0007, 32'hC0FFEE11, 1, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule